// File: doc/BRIEF.md
# DRAM Power-Up and CAS-Before-RAS Refresh Sequencer

This block owns the row strobe, column strobe and write-enable lines of an asynchronous DRAM for two jobs: bringing the memory up after power-on, and running hidden-address refresh cycles in which the column strobe drops ahead of the row strobe. After reset it stays silent for a long power-up pause. It then runs a fixed burst of refresh cycles and raises `ready`. From then on, each pulse on `rfsh_req` from an external interval timer produces exactly one refresh cycle.

The strobes are shared with other masters. The sequencer raises `bus_req`, waits for `bus_gnt`, and keeps the grant until the cycle has fully precharged. Every timing window is given in nanoseconds and turned into a clock count, rounded up, from the clock period parameter.

The controller moves through these states:
- `S_PAUSE`: power-up wait.
- `S_IDLE`: nothing to do.
- `S_GRANT`: bus requested. The strobes stay high until the grant has been held for the pre-refresh settle time.
- `S_CAS_LOW`: column strobe low for its setup window.
- `S_RAS_LOW`: both strobes low for the column hold window.
- `S_HOLD`: row strobe alone low until the row active width is met.
- `S_PRECHARGE`: all strobes high while the bus is still held.
- `S_DONE`: bus released, and one init refresh is counted off.

The transitions are:
- PAUSE→IDLE when the pause expires.
- IDLE→GRANT when init refreshes remain or a request is pending.
- GRANT→CAS_LOW after the settle time under grant.
- CAS_LOW→RAS_LOW, RAS_LOW→HOLD, HOLD→PRECHARGE and PRECHARGE→DONE, each when its own count expires.
- DONE→IDLE, always.

Top module: `dram_cbr_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high, and `bus_req` and `ready` are low.
- R2: After reset is released, no strobe goes low and `bus_req` stays low for at least ceil(PAUSE_NS/period) cycles. This is 40000 cycles at the defaults (200 us at 5 ns).
- R3: After the pause, exactly INIT_REFRESHES (8) refresh cycles take place before `ready` rises, and `ready` never falls afterwards.
- R4: In every refresh, `cas_n` is low for at least ceil(10 ns/period) cycles before `ras_n` falls, and `ras_n` never falls while `cas_n` is high.
- R5: `we_n` stays high throughout. In particular it is high for at least ceil(15 ns/period) cycles before, and ceil(8 ns/period) cycles after, every fall of `ras_n`.
- R6: `cas_n` stays low for at least max(ceil(8 ns), ceil(8 ns)) cycles after `ras_n` falls. `ras_n` stays low for at least ceil(T_RAS_NS/period) cycles, which is 12 at the defaults.
- R7: `cas_n` falls only after `bus_gnt` has been high with all strobes high for at least max(ceil(3 ns), ceil(15 ns)) cycles. `bus_req` stays high for at least ceil(T_RP_NS/period) cycles after `ras_n` rises, which is 8 at the defaults.
- R8: A strobe is low only while both `bus_req` and `bus_gnt` are high.
- R9: Once `ready` is high, each one-cycle pulse on `rfsh_req` yields exactly one refresh cycle, and no refresh starts without a request.
- R10: A request that arrives while a refresh is in progress is held and served by the next cycle. Several requests that arrive during one cycle merge into a single further refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its period is the CLK_PS parameter |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfsh_req | input | 1 | One-cycle refresh request from the interval timer |
| bus_gnt | input | 1 | Grant of the strobe lines from the arbiter |
| bus_req | output | 1 | Request for the strobe lines |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready | output | 1 | Power-up sequence complete |

## Verification
The bench measures every strobe window at each refresh. A design that dropped the row strobe too early, released the column strobe before the hold window, or gave back the bus before precharge would show a count below the expected minimum. The grant is delayed by a random number of cycles, so a design that drove the strobes before the grant, or without the settle time after it, is caught. Requests are pulsed while a row strobe is low, both singly and three at a time. A design that cleared its pending flag at the end of a cycle would lose the second request, and one that counted requests rather than merging them would refresh too often. The refresh count at the rise of `ready` catches an off-by-one in the init burst.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        S_PAUSE,
        S_IDLE,
        S_GRANT,
        S_CAS_LOW,
        S_RAS_LOW,
        S_HOLD,
        S_PRECHARGE,
        S_DONE
    } rf_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
        longint unsigned num;
        longint unsigned c;
        num = longint'(ns) * 64'd1000 + longint'(period_ps) - 64'd1;
        c   = num / longint'(period_ps);
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rf_timer.sv
module rf_timer #(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rf_init_ctr.sv
module rf_init_ctr #(
    parameter int unsigned N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec,
    output logic ready
);
    localparam int unsigned CW = $clog2(N + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    left <= CW'(N);
        else if (dec && left != '0)    left <= left - 1'b1;
    end

    assign ready = (left == '0);

    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/rf_req_latch.sv
module rf_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend <= 1'b0;
        else if (req)   pend <= 1'b1;   // a new request wins over a take
        else if (take)  pend <= 1'b0;
    end

    p_req_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pend);

endmodule

// File: rtl/rf_fsm.sv
module rf_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned PRE_C  = 3,
    parameter int unsigned CSR_C  = 2,
    parameter int unsigned HLD_C  = 2,
    parameter int unsigned RST_C  = 10,
    parameter int unsigned RP_C   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ready,
    input  logic         pend,
    input  logic         bus_gnt,
    input  logic         tmr_zero,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         take_req,
    output logic         init_dec,
    output logic         bus_req,
    output logic         ras_n,
    output logic         cas_n,
    output logic         we_n
);
    localparam logic [W-1:0] L_PRE = W'(PRE_C - 1);
    localparam logic [W-1:0] L_CSR = W'(CSR_C - 1);
    localparam logic [W-1:0] L_HLD = W'(HLD_C - 1);
    localparam logic [W-1:0] L_RST = W'(RST_C - 1);
    localparam logic [W-1:0] L_RP  = W'(RP_C - 1);

    rf_state_e st, nxt;

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take_req = 1'b0;
        init_dec = 1'b0;
        unique case (st)
            S_PAUSE: begin
                if (tmr_zero) nxt = S_IDLE;
            end
            S_IDLE: begin
                if (!ready) begin
                    nxt = S_GRANT; tmr_load = 1'b1; tmr_val = L_PRE;
                end else if (pend) begin
                    nxt = S_GRANT; tmr_load = 1'b1; tmr_val = L_PRE;
                    take_req = 1'b1;
                end
            end
            S_GRANT: begin
                if (!bus_gnt) begin
                    tmr_load = 1'b1; tmr_val = L_PRE;
                end else if (tmr_zero) begin
                    nxt = S_CAS_LOW; tmr_load = 1'b1; tmr_val = L_CSR;
                end
            end
            S_CAS_LOW: begin
                if (tmr_zero) begin
                    nxt = S_RAS_LOW; tmr_load = 1'b1; tmr_val = L_HLD;
                end
            end
            S_RAS_LOW: begin
                if (tmr_zero) begin
                    nxt = S_HOLD; tmr_load = 1'b1; tmr_val = L_RST;
                end
            end
            S_HOLD: begin
                if (tmr_zero) begin
                    nxt = S_PRECHARGE; tmr_load = 1'b1; tmr_val = L_RP;
                end
            end
            S_PRECHARGE: begin
                if (tmr_zero) nxt = S_DONE;
            end
            S_DONE: begin
                nxt      = S_IDLE;
                init_dec = !ready;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_PAUSE;
        else        st <= nxt;
    end

    // outputs registered from the next state so they line up with st
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            we_n    <= 1'b1;
            bus_req <= 1'b0;
        end else begin
            ras_n   <= !(nxt == S_RAS_LOW || nxt == S_HOLD);
            cas_n   <= !(nxt == S_CAS_LOW || nxt == S_RAS_LOW);
            we_n    <= 1'b1;
            bus_req <= (nxt == S_GRANT || nxt == S_CAS_LOW || nxt == S_RAS_LOW ||
                        nxt == S_HOLD  || nxt == S_PRECHARGE);
        end
    end

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PAUSE) |-> (ras_n && cas_n && !bus_req));

    p_cas_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    p_cas_rises_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> !ras_n);

    p_strobe_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> (bus_req && bus_gnt));

    p_one_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_dec |-> !ready);

endmodule

// File: rtl/dram_cbr_seq.sv
module dram_cbr_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_PS         = 5000,
    parameter int unsigned PAUSE_NS       = 200000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned T_CSR_NS       = 10,
    parameter int unsigned T_CHR_NS       = 8,
    parameter int unsigned T_WRP_NS       = 15,
    parameter int unsigned T_WRH_NS       = 8,
    parameter int unsigned T_RPC_NS       = 3,
    parameter int unsigned T_RAS_NS       = 60,
    parameter int unsigned T_RP_NS        = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_req,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready
);
    localparam int unsigned PAUSE_C = ns_to_cyc(PAUSE_NS, CLK_PS);
    localparam int unsigned CSR_C   = ns_to_cyc(T_CSR_NS, CLK_PS);
    localparam int unsigned HLD_C   = max2(ns_to_cyc(T_CHR_NS, CLK_PS), ns_to_cyc(T_WRH_NS, CLK_PS));
    localparam int unsigned PRE_C   = max2(ns_to_cyc(T_RPC_NS, CLK_PS), ns_to_cyc(T_WRP_NS, CLK_PS));
    localparam int unsigned RAS_C   = ns_to_cyc(T_RAS_NS, CLK_PS);
    localparam int unsigned RST_C   = (RAS_C > HLD_C) ? (RAS_C - HLD_C) : 1;
    localparam int unsigned RP_C    = ns_to_cyc(T_RP_NS, CLK_PS);
    localparam int unsigned BIG_C   = max2(max2(PAUSE_C, RAS_C), max2(RP_C, max2(PRE_C, CSR_C)));
    localparam int unsigned TW      = $clog2(BIG_C + 1);

    logic          tmr_load, tmr_zero, take_req, init_dec, pend;
    logic [TW-1:0] tmr_val;

    rf_timer #(.W(TW), .RST_VAL(PAUSE_C - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    rf_init_ctr #(.N(INIT_REFRESHES)) u_init (
        .clk(clk), .rst_n(rst_n), .dec(init_dec), .ready(ready)
    );

    rf_req_latch u_latch (
        .clk(clk), .rst_n(rst_n), .req(rfsh_req), .take(take_req), .pend(pend)
    );

    rf_fsm #(
        .W(TW), .PRE_C(PRE_C), .CSR_C(CSR_C), .HLD_C(HLD_C), .RST_C(RST_C), .RP_C(RP_C)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ready(ready), .pend(pend), .bus_gnt(bus_gnt),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .take_req(take_req), .init_dec(init_dec), .bus_req(bus_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

endmodule

// File: tb/test_dram_cbr_seq.sv
`timescale 1ns/1ps
module test_dram_cbr_seq;
    localparam int CLK_PS = 5000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int PAUSE = 40000;
    localparam int INITN = 8;

    logic clk = 1'b0, rst_n = 1'b0, rfsh_req = 1'b0, bus_gnt = 1'b0;
    logic bus_req, ras_n, cas_n, we_n, ready;

    always #2.5 clk = ~clk;

    dram_cbr_seq i_dram_cbr_seq (
        .clk(clk), .rst_n(rst_n), .rfsh_req(rfsh_req), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
    );

    int total = 0, bad = 0;
    int falls = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // arbiter model with random grant latency
    initial begin
        int dly = 0;
        forever begin
            @(posedge clk); #1;
            if (bus_req && !bus_gnt) begin
                if (dly == 0) bus_gnt = 1'b1; else dly--;
            end else if (!bus_req) begin
                bus_gnt = 1'b0;
                dly = $urandom_range(0, 4);
            end
        end
    end

    // monitor of strobe windows
    bit mon_on = 0;
    initial begin
        int cas_lo = 0, both_lo = 0, ras_lo = 0, pre = 0, gnt_hi = 0, we_hi = 0, since = 0;
        int viol = 0, we_bad = 0;
        bit pr = 1, pc = 1, pb = 0, prd = 0, seen = 0;
        wait (mon_on);
        while (!done) begin
            @(negedge clk);
            since++;
            if (!seen && (bus_req || !ras_n || !cas_n)) begin
                seen = 1;
                check(since > PAUSE, "R2", since, PAUSE);
            end
            if (!ras_n && pr) begin
                falls++;
                check(!cas_n && cas_lo >= cyc(10), "R4", cas_lo, cyc(10));
                check(we_hi >= cyc(15), "R5", we_hi, cyc(15));
            end
            if (cas_n && !pc) check(both_lo >= mx(cyc(8), cyc(8)), "R6", both_lo, cyc(8));
            if (ras_n && !pr) check(ras_lo >= cyc(60), "R6", ras_lo, cyc(60));
            if (!bus_req && pb) check(pre >= cyc(40), "R7", pre, cyc(40));
            if (!cas_n && pc) check(gnt_hi >= mx(cyc(3), cyc(15)), "R7", gnt_hi, mx(cyc(3), cyc(15)));
            if (ready && !prd) check(falls == INITN, "R3", falls, INITN);
            if (!ready && prd) check(0, "R3", 0, 1);
            if ((!ras_n || !cas_n || !we_n) && !(bus_gnt && bus_req)) viol++;
            if (!we_n) we_bad++;
            cas_lo  = !cas_n ? cas_lo + 1 : 0;
            both_lo = (!cas_n && !ras_n) ? both_lo + 1 : 0;
            ras_lo  = !ras_n ? ras_lo + 1 : 0;
            pre     = (ras_n && bus_req) ? pre + 1 : 0;
            gnt_hi  = (bus_gnt && cas_n) ? gnt_hi + 1 : 0;
            we_hi   = we_n ? we_hi + 1 : 0;
            pr = ras_n; pc = cas_n; pb = bus_req; prd = ready;
            if (since % 1000 == 0 && since > PAUSE) begin
                check(viol == 0, "R8", viol, 0);
                check(we_bad == 0, "R5", we_bad, 0);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    task automatic pulse();
        @(negedge clk) rfsh_req = 1'b1;
        @(negedge clk) rfsh_req = 1'b0;
    endtask

    task automatic wait_ras_low();
        int n = 0;
        while (ras_n && n < 500) begin @(negedge clk); n++; end
    endtask

    initial begin
        int exp_f;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        // R1 reset state
        check(ras_n && cas_n && we_n, "R1", {ras_n, cas_n, we_n}, 7);
        check(!bus_req && !ready, "R1", {bus_req, ready}, 0);
        rst_n = 1'b1;
        mon_on = 1;
        begin
            int n = 0;
            while (!ready && n < 60000) begin @(negedge clk); n++; end
        end
        check(ready, "R3", ready, 1);
        repeat (3) @(negedge clk);
        check(falls == INITN, "R3", falls, INITN);
        exp_f = falls;

        // R9: no refresh without request
        repeat (150) @(negedge clk);
        check(falls == exp_f, "R9", falls, exp_f);

        // R9: single request, single refresh
        pulse(); exp_f++;
        repeat (120) @(negedge clk);
        check(falls == exp_f, "R9", falls, exp_f);

        // R10: request during an active cycle is served next
        pulse(); exp_f += 2;
        wait_ras_low();
        pulse();
        repeat (160) @(negedge clk);
        check(falls == exp_f, "R10", falls, exp_f);

        // R10: several requests in one cycle merge
        pulse(); exp_f += 2;
        wait_ras_low();
        pulse(); pulse(); pulse();
        repeat (160) @(negedge clk);
        check(falls == exp_f, "R10", falls, exp_f);

        // R9: random spaced requests
        for (int i = 0; i < 20; i++) begin
            pulse(); exp_f++;
            repeat ($urandom_range(70, 150)) @(negedge clk);
            check(falls == exp_f, "R9", falls, exp_f);
        end

        check(ready, "R3", ready, 1);
        check(ras_n && cas_n && we_n && !bus_req, "R8", {ras_n, cas_n, we_n, bus_req}, 14);
        finish_run();
    end

endmodule